// File: doc/BRIEF.md
# Asynchronous Bus Master Cycle Sequencer

This block turns single-word requests from a core into read and write cycles on an asynchronous, strobe-based external bus. Each cycle is a sequence of half-clock states S0 to S7. The clock `clk` runs at the half-clock rate, so one tick of `clk` is one state, and two ticks make one bus clock. The sequencer places the address and the direction, asserts the address strobe, and drives the upper and lower data strobes from the requested byte enables. It then waits for the slave's active-low acknowledge. While the acknowledge is absent it adds wait states, one bus clock at a time. It captures read data and returns a one-tick completion pulse to the core.

The acknowledge is a level. It passes through a two-flop synchronizer before any state decision uses it, so a slave can drive it with no relation to the clock. If the acknowledge is tied low permanently, every cycle runs at the minimum length of four bus clocks. The core pulses `req_valid` for one tick while the sequencer is idle. A pulse that arrives while a cycle is in progress is dropped.

Top module: `asb_master`

## Requirements
- R1: While `rst` is high and in the first tick after it, `bus_as_n`, `bus_uds_n` and `bus_lds_n` are high, `bus_rw_n` is high, `bus_doe` is low and `resp_done` is low.
- R2: A `req_valid` pulse in the idle state is accepted at that clock edge, and that edge starts S0. From S1 on, `bus_addr` carries the request address and `bus_rw_n` carries the direction (0 = write, 1 = read). Both stay unchanged while `bus_as_n` is low.
- R3: On a read, the data strobes are low in exactly the ticks where `bus_as_n` is low. On a write, the data strobes assert two ticks after `bus_as_n`, in S4, and they negate together with it.
- R4: The acknowledge is first examined at the edge that ends S4. If it was already low during S2, the cycle has no wait states. In that case `bus_as_n` is low for 6 ticks, and `resp_done` is high in the 9th tick after the accepting edge.
- R5: Every examination that does not find the acknowledge adds one wait bus clock, which is 2 ticks. The next examination comes one bus clock later. An acknowledge that first goes low in tick k after S0 (counting from S0 = 0) gives ceil((k-2)/2) wait clocks, and never fewer than zero.
- R6: The acknowledge is treated as a level. A low acknowledge left over from the previous cycle, or held low permanently, gives zero-wait cycles one after another. `bus_as_n` is high for at least one tick between them.
- R7: On a read, the value on `bus_din` at the edge that ends S6 is returned on `resp_rdata`.
- R8: Byte enable bit 1 selects the upper lane (`bus_uds_n`) and bit 0 selects the lower lane (`bus_lds_n`). The value 2'b11 asserts both strobes, and so does 2'b00, which is treated as a word access.
- R9: `resp_done` is high for exactly one tick, the tick after S7. In that same tick `bus_as_n` returns high.
- R10: A `req_valid` pulse that arrives while a cycle is in progress is ignored. No further cycle follows.
- R11: On a write, `bus_doe` is high from S3 through S7, and `bus_dout` carries the write data during that time. On a read, `bus_doe` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bus-clock tick clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-tick request pulse |
| req_addr | input | ADDR_W | Word address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables, bit 1 upper and bit 0 lower |
| req_wdata | input | 16 | Write data |
| resp_done | output | 1 | One-tick completion pulse |
| resp_rdata | output | 16 | Captured read data |
| bus_addr | output | ADDR_W | Bus address |
| bus_rw_n | output | 1 | Direction, low for write |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_uds_n | output | 1 | Upper data strobe, active low |
| bus_lds_n | output | 1 | Lower data strobe, active low |
| bus_dout | output | 16 | Write data to the bus |
| bus_doe | output | 1 | Output enable for `bus_dout` |
| bus_din | input | 16 | Read data from the bus |
| bus_ack_n | input | 1 | Transfer acknowledge, active low, asynchronous |

## Verification
Every result has a fixed due time, counted from the edge that accepts a request. `resp_done` is due in tick 9+2w, where w is the number of wait clocks. `bus_as_n` should be low for 6+2w ticks. The data strobes should be low for 6+2w ticks on a read and 4+2w ticks on a write, and `bus_doe` for 5+2w ticks on a write. The bench emulates a slave that acknowledges a set number of ticks after the address strobe. From that delay it computes w as ceil((k-2)/2), counts ticks on the falling half of `clk`, and compares each count and each sampled value with these figures.

// File: rtl/asb_pkg.sv
package asb_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [3:0] {
        ST_IDLE, ST_S0, ST_S1, ST_S2, ST_S3, ST_S4,
        ST_W0, ST_W1, ST_S5, ST_S6, ST_S7
    } seq_state_e;

    typedef struct packed {
        logic upper;
        logic lower;
    } lane_sel_t;

    // Byte enables to strobe lanes; no enable at all means a full word.
    function automatic lane_sel_t lane_decode(input logic [LANES-1:0] be);
        lane_sel_t l;
        if (be == '0) begin
            l.upper = 1'b1;
            l.lower = 1'b1;
        end else begin
            l.upper = be[1];
            l.lower = be[0];
        end
        return l;
    endfunction

    // States during which the address strobe is held asserted.
    function automatic logic strobe_phase(input seq_state_e s);
        return (s == ST_S2) || (s == ST_S3) || (s == ST_S4) ||
               (s == ST_W0) || (s == ST_W1) || (s == ST_S5) ||
               (s == ST_S6) || (s == ST_S7);
    endfunction

endpackage

// File: rtl/asb_ack_sync.sv
module asb_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_n_i,
    output logic ack_seen_o
);
    logic [STAGES-1:0] chain_q;

    generate
        genvar g;
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b1;
                    else     chain_q[0] <= ack_n_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b1;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign ack_seen_o = ~chain_q[STAGES-1];
endmodule

// File: rtl/asb_seq_fsm.sv
module asb_seq_fsm
    import asb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       ack_seen,
    output seq_state_e state_o,
    output logic       accept_o
);
    seq_state_e state_q, state_d;

    assign accept_o = req_valid && (state_q == ST_IDLE);
    assign state_o  = state_q;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_S0;
            ST_S0:   state_d = ST_S1;
            ST_S1:   state_d = ST_S2;
            ST_S2:   state_d = ST_S3;
            ST_S3:   state_d = ST_S4;
            ST_S4:   state_d = ack_seen ? ST_S5 : ST_W0;
            ST_W0:   state_d = ST_W1;
            ST_W1:   state_d = ack_seen ? ST_S5 : ST_W0;
            ST_S5:   state_d = ST_S6;
            ST_S6:   state_d = ST_S7;
            ST_S7:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/asb_bus_drive.sv
module asb_bus_drive
    import asb_pkg::*;
#(
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [LANES-1:0]  req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rw_n,
    output logic              bus_as_n,
    output logic              bus_uds_n,
    output logic              bus_lds_n,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              resp_done,
    output logic [DATA_W-1:0] resp_rdata
);
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    lane_sel_t         lanes_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              done_q;
    logic              addr_phase, as_on, ds_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            lanes_q <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            lanes_q <= lane_decode(req_be);
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state == ST_S7);
            if (state == ST_S6 && !write_q) rdata_q <= bus_din;
        end
    end

    assign addr_phase = (state != ST_IDLE) && (state != ST_S0);
    assign as_on      = strobe_phase(state);
    assign ds_on      = as_on && !(write_q && (state == ST_S2 || state == ST_S3));

    assign bus_addr   = addr_q;
    assign bus_rw_n   = !(write_q && addr_phase);
    assign bus_as_n   = !as_on;
    assign bus_uds_n  = !(ds_on && lanes_q.upper);
    assign bus_lds_n  = !(ds_on && lanes_q.lower);
    assign bus_doe    = write_q && as_on && (state != ST_S2);
    assign bus_dout   = wdata_q;
    assign resp_done  = done_q;
    assign resp_rdata = rdata_q;
endmodule

// File: rtl/asb_master.sv
module asb_master
    import asb_pkg::*;
#(
    parameter int ADDR_W      = 23,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_be,
    input  logic [15:0]       req_wdata,
    output logic              resp_done,
    output logic [15:0]       resp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rw_n,
    output logic              bus_as_n,
    output logic              bus_uds_n,
    output logic              bus_lds_n,
    output logic [15:0]       bus_dout,
    output logic              bus_doe,
    input  logic [15:0]       bus_din,
    input  logic              bus_ack_n
);
    seq_state_e state;
    logic       accept;
    logic       ack_seen;

    asb_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .ack_n_i(bus_ack_n), .ack_seen_o(ack_seen)
    );

    asb_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .ack_seen(ack_seen),
        .state_o(state), .accept_o(accept)
    );

    asb_bus_drive #(.ADDR_W(ADDR_W)) u_drive (
        .clk(clk), .rst(rst), .state(state), .accept(accept),
        .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
        .req_wdata(req_wdata), .bus_din(bus_din),
        .bus_addr(bus_addr), .bus_rw_n(bus_rw_n), .bus_as_n(bus_as_n),
        .bus_uds_n(bus_uds_n), .bus_lds_n(bus_lds_n), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .resp_done(resp_done), .resp_rdata(resp_rdata)
    );
endmodule

// File: rtl/asb_master_chk.sv
module asb_master_chk #(
    parameter int ADDR_W = 23
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_as_n,
    input logic              bus_uds_n,
    input logic              bus_lds_n,
    input logic              bus_rw_n,
    input logic              bus_doe,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              resp_done
);
    logic [7:0] as_run;

    always_ff @(posedge clk) begin
        if (rst || bus_as_n) as_run <= '0;
        else if (as_run != 8'hFF) as_run <= as_run + 8'd1;
    end

    p_ds_inside_as_r3: assert property (@(posedge clk) disable iff (rst)
        (!bus_uds_n || !bus_lds_n) |-> !bus_as_n);

    p_min_length_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_as_n) |-> (as_run >= 8'd6));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!bus_as_n && $past(!bus_as_n)) |-> ($stable(bus_addr) && $stable(bus_rw_n)));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        resp_done |=> !resp_done);

    p_done_with_release_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_as_n) |-> resp_done);

    p_oe_write_only_r11: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> (!bus_rw_n && !bus_as_n));
endmodule

bind asb_master asb_master_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
    .bus_lds_n(bus_lds_n), .bus_rw_n(bus_rw_n), .bus_doe(bus_doe),
    .bus_addr(bus_addr), .resp_done(resp_done)
);

// File: tb/asb_master_test.sv
`timescale 1ns/1ps
module asb_master_test;
    localparam int AW = 23;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic [1:0]    req_be = 2'b11;
    logic [15:0]   req_wdata = '0;
    logic          resp_done;
    logic [15:0]   resp_rdata;
    logic [AW-1:0] bus_addr;
    logic          bus_rw_n, bus_as_n, bus_uds_n, bus_lds_n, bus_doe;
    logic [15:0]   bus_dout;
    logic [15:0]   bus_din = '0;
    logic          bus_ack_n = 1'b1;

    always #5 clk = ~clk;

    asb_master #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
        .resp_done(resp_done), .resp_rdata(resp_rdata), .bus_addr(bus_addr),
        .bus_rw_n(bus_rw_n), .bus_as_n(bus_as_n), .bus_uds_n(bus_uds_n),
        .bus_lds_n(bus_lds_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
        .bus_din(bus_din), .bus_ack_n(bus_ack_n)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // slave emulation settings and bus observations
    int  ack_delay = 1;
    bit  ack_stuck = 0;
    int  rcnt = 0;
    int  as_cnt, ds_cnt, oe_cnt;
    bit  uds_seen, lds_seen, first_as;
    logic [AW-1:0] addr_seen;
    logic          rw_seen;
    logic [15:0]   wdata_seen;

    function automatic logic [15:0] rd_pattern(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_obs();
        as_cnt = 0; ds_cnt = 0; oe_cnt = 0;
        uds_seen = 0; lds_seen = 0; first_as = 1;
        addr_seen = '0; rw_seen = 1'b1; wdata_seen = '0;
    endtask

    // monitor and slave, both on the falling half of clk
    initial begin
        clear_obs();
        forever begin
            @(negedge clk);
            if (!bus_as_n) begin
                as_cnt++;
                if (first_as) begin
                    addr_seen = bus_addr;
                    rw_seen   = bus_rw_n;
                    first_as  = 0;
                end
            end
            if (!bus_uds_n || !bus_lds_n) ds_cnt++;
            if (!bus_uds_n) uds_seen = 1;
            if (!bus_lds_n) lds_seen = 1;
            if (bus_doe) begin
                oe_cnt++;
                wdata_seen = bus_dout;
            end
            if (ack_stuck) bus_ack_n = 1'b0;
            else if (!bus_as_n) begin
                rcnt++;
                bus_ack_n = (rcnt >= ack_delay) ? 1'b0 : 1'b1;
            end else begin
                rcnt = 0;
                bus_ack_n = 1'b1;
            end
            bus_din = (!bus_as_n && bus_rw_n) ? rd_pattern(bus_addr) : 16'h0000;
        end
    end

    // one full cycle; the slave acknowledges from tick k = 1 + ack_delay after S0
    task automatic run_cycle(input logic [AW-1:0] a, input bit wr, input logic [1:0] be,
                             input logic [15:0] wd, input int waits, input string tag);
        int lat;
        bit exp_u, exp_l;
        clear_obs();
        req_addr = a; req_write = wr; req_be = be; req_wdata = wd; req_valid = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) req_valid = 1'b0;
        end while (!resp_done && lat < 300);
        chk(lat == 9 + 2*waits, {tag, " R4 R5 done latency"}, lat, 9 + 2*waits);
        chk(bus_as_n == 1'b1, {tag, " R9 strobe released with done"}, bus_as_n, 1);
        chk(as_cnt == 6 + 2*waits, {tag, " R5 strobe length"}, as_cnt, 6 + 2*waits);
        chk(addr_seen == a, {tag, " R2 address"}, addr_seen, a);
        chk(rw_seen == !wr, {tag, " R2 direction"}, rw_seen, !wr);
        exp_u = (be == 2'b00) ? 1'b1 : be[1];
        exp_l = (be == 2'b00) ? 1'b1 : be[0];
        chk(uds_seen == exp_u && lds_seen == exp_l, {tag, " R8 lanes"},
            {uds_seen, lds_seen}, {exp_u, exp_l});
        if (wr) begin
            chk(ds_cnt == 4 + 2*waits, {tag, " R3 write strobe length"}, ds_cnt, 4 + 2*waits);
            chk(oe_cnt == 5 + 2*waits, {tag, " R11 drive length"}, oe_cnt, 5 + 2*waits);
            chk(wdata_seen == wd, {tag, " R11 write data"}, wdata_seen, wd);
        end else begin
            chk(ds_cnt == 6 + 2*waits, {tag, " R3 read strobe length"}, ds_cnt, 6 + 2*waits);
            chk(oe_cnt == 0, {tag, " R11 no drive on read"}, oe_cnt, 0);
            chk(resp_rdata == rd_pattern(a), {tag, " R7 read data"}, resp_rdata, rd_pattern(a));
        end
        @(negedge clk);
        chk(resp_done == 1'b0, {tag, " R9 one tick done"}, resp_done, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(bus_as_n && bus_uds_n && bus_lds_n, "R1 strobes in reset",
            {bus_as_n, bus_uds_n, bus_lds_n}, 3'b111);
        chk(bus_rw_n && !bus_doe && !resp_done, "R1 rw doe done in reset",
            {bus_rw_n, bus_doe, resp_done}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_as_n && bus_rw_n && !bus_doe && !resp_done, "R1 idle after reset",
            {bus_as_n, bus_rw_n, bus_doe, resp_done}, 4'b1100);
    endtask

    task automatic t_zero_wait();
        ack_stuck = 0; ack_delay = 1;
        run_cycle(23'h001234, 1'b0, 2'b11, 16'h0, 0, "zero-wait read");
    endtask

    task automatic t_waits();
        ack_stuck = 0;
        ack_delay = 2; run_cycle(23'h00BEEF, 1'b0, 2'b11, 16'h0, 1, "wait d2");
        ack_delay = 3; run_cycle(23'h000F0F, 1'b0, 2'b11, 16'h0, 1, "wait d3");
        ack_delay = 7; run_cycle(23'h007777, 1'b0, 2'b11, 16'h0, 3, "wait d7");
    endtask

    task automatic t_write();
        ack_stuck = 0;
        ack_delay = 1; run_cycle(23'h000100, 1'b1, 2'b11, 16'hC0DE, 0, "write zw");
        ack_delay = 4; run_cycle(23'h000200, 1'b1, 2'b11, 16'h1357, 2, "write d4");
    endtask

    task automatic t_lanes();
        ack_stuck = 0; ack_delay = 1;
        run_cycle(23'h000300, 1'b0, 2'b10, 16'h0, 0, "upper only");
        run_cycle(23'h000301, 1'b1, 2'b01, 16'h00AA, 0, "lower only");
        run_cycle(23'h000302, 1'b0, 2'b00, 16'h0, 0, "no enables word");
    endtask

    // R6: acknowledge held low gives back-to-back zero-wait cycles
    task automatic t_stuck_ack();
        ack_stuck = 1;
        repeat (3) @(negedge clk);
        run_cycle(23'h004000, 1'b0, 2'b11, 16'h0, 0, "R6 stuck ack 1");
        run_cycle(23'h004001, 1'b1, 2'b11, 16'h5555, 0, "R6 stuck ack 2");
        run_cycle(23'h004002, 1'b0, 2'b01, 16'h0, 0, "R6 stuck ack 3");
        ack_stuck = 0;
        repeat (3) @(negedge clk);
    endtask

    // R10: a request during an active cycle is dropped
    task automatic t_busy_ignore();
        int lat;
        int extra;
        ack_stuck = 0; ack_delay = 4;
        clear_obs();
        req_addr = 23'h00A0A0; req_write = 1'b0; req_be = 2'b11; req_valid = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) req_valid = 1'b0;
            if (lat == 4) begin
                req_addr = 23'h00B0B0; req_valid = 1'b1;
            end
            if (lat == 5) req_valid = 1'b0;
        end while (!resp_done && lat < 300);
        chk(lat == 13, "R10 first cycle latency", lat, 13);
        chk(resp_rdata == rd_pattern(23'h00A0A0), "R10 first read data",
            resp_rdata, rd_pattern(23'h00A0A0));
        extra = 0;
        repeat (14) begin
            @(negedge clk);
            if (!bus_as_n) extra++;
        end
        chk(extra == 0, "R10 no second cycle", extra, 0);
        chk(addr_seen == 23'h00A0A0, "R10 address kept", addr_seen, 23'h00A0A0);
    endtask

    initial begin
        t_reset();
        t_zero_wait();
        t_waits();
        t_write();
        t_lanes();
        t_stuck_ack();
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule